// File: doc/BRIEF.md
# Ethernet Transmit Buffer Write Port

This block sits between a CPU register bus and the write side of a transmit buffer that a link transmitter empties. Software pushes a frame one 32-bit word at a time. It can use either of two data registers. The non-blocking register never stalls the bus: if the buffer has no room, the word is lost and the frame is aborted. The blocking register holds the bus with a wait request until the buffer reports room, and then takes the word.

Software stages frame markers in a control register before it writes the last word of a frame. These are an end-of-packet flag and a two-bit count of padding bytes. Both travel with the next word pushed and then clear themselves. A discard bit in the same register throws away the frame in progress. Any abort raises a sticky status flag, and software clears that flag by writing a one to it. While the flag is up, data writes are swallowed. When a frame in progress is aborted, a one-cycle abort strobe tells the buffer to flush the words already stored, so a truncated frame is never sent as valid.

The status register shows two room levels taken from the buffer's free-word count. One level means there is room for a single word. The other means there is room for a whole chunk of `CHUNK_WORDS` words.

Top module: `eth_tx_wrport`

## Requirements
- R1: After reset, the status abort flag (bit 2) reads 0, the control register reads 0, and no buffer write or abort strobe is issued while the bus is idle.
- R2: Status bit 0 reads 1 exactly when `buf_free` >= 1. Status bit 1 reads 1 exactly when `buf_free` >= `CHUNK_WORDS` (default 8).
- R3: A write to the non-blocking data register (address 0) while `buf_free` > 0 and the abort flag is clear drives `buf_wr_en` in that same cycle with the bus data. `buf_wr_sop` is 1 on the first word after reset, after an end-of-packet word, or after an abort.
- R4: A write to the non-blocking data register while `buf_free` = 0 pushes nothing and sets the abort flag.
- R5: A write to the blocking data register (address 1) while `buf_free` = 0 holds `csr_waitreq` high and pushes nothing. In the first cycle that `buf_free` > 0, the wait request drops and the word is pushed.
- R6: Control register (address 2): bit 0 is end-of-packet and bits 2:1 are the padding byte count. The next pushed word carries `buf_wr_eop` = bit 0 and `buf_wr_pad` = bits 2:1. After that push both fields read 0 and the following word carries `buf_wr_sop`.
- R7: Every pushed word that is not an end-of-packet word has `buf_wr_pad` = 0.
- R8: Writing 1 to control bit 3 (discard) sets the abort flag and clears the staged end-of-packet and padding, even when other control bits are written with it.
- R9: `buf_abort` pulses for one cycle on any abort (R4 or R8) while a frame is in progress, meaning at least one word has been pushed since its start of frame. It stays 0 when the abort hits between frames.
- R10: While the abort flag is set, writes to either data register push nothing and raise no wait request. Writing 1 to status bit 2 (address 3) clears the flag, and the next pushed word carries `buf_wr_sop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 2 | Word address: 0 data non-blocking, 1 data blocking, 2 control, 3 status |
| csr_write | input | 1 | Bus write strobe |
| csr_read | input | 1 | Bus read strobe |
| csr_wdata | input | 32 | Bus write data |
| csr_rdata | output | 32 | Bus read data, valid in the cycle of `csr_read` |
| csr_waitreq | output | 1 | Stalls a blocking data write |
| buf_free | input | FREE_W | Free word count reported by the buffer |
| buf_wr_en | output | 1 | Push one word into the buffer |
| buf_wr_data | output | 32 | Word being pushed |
| buf_wr_sop | output | 1 | Pushed word starts a frame |
| buf_wr_eop | output | 1 | Pushed word ends a frame |
| buf_wr_pad | output | 2 | Padding bytes in the end-of-packet word |
| buf_abort | output | 1 | Flush the partial frame held in the buffer |

## Verification
The assertions assume that `buf_free` changes only between clock edges and counts the words the buffer can still take. They also assume the bus holds a stalled blocking write, with the same address and data, until the wait request drops. The bench drives every input just after the falling edge. It releases `buf_free` only while a blocking write is pending, and it never moves a stalled write. With these rules the wait and push relations hold at every rising edge.

// File: rtl/eth_txw_pkg.sv
package eth_txw_pkg;

  typedef enum logic [1:0] {
    SEL_DATA_NB = 2'd0,
    SEL_DATA_WT = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_STAT    = 2'd3
  } reg_sel_e;

  localparam int CTRL_EOP_BIT  = 0;
  localparam int CTRL_PAD_LSB  = 1;
  localparam int CTRL_DISC_BIT = 3;
  localparam int STAT_ONE_BIT  = 0;
  localparam int STAT_CHK_BIT  = 1;
  localparam int STAT_ABT_BIT  = 2;

  typedef struct packed {
    logic       eop;
    logic [1:0] pad;
  } staged_t;

endpackage

// File: rtl/eth_txw_room.sv
module eth_txw_room #(
  parameter int FREE_W      = 6,
  parameter int CHUNK_WORDS = 8
) (
  input  logic [FREE_W-1:0] buf_free,
  output logic              room_one,
  output logic              room_chunk
);

  localparam logic [FREE_W-1:0] CHUNK_LVL = FREE_W'(CHUNK_WORDS);

  always_comb begin
    room_one   = (buf_free != '0);
    room_chunk = (buf_free >= CHUNK_LVL);
  end

endmodule

// File: rtl/eth_txw_ctrl.sv
module eth_txw_ctrl
  import eth_txw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       ctrl_eop_in,
  input  logic [1:0] ctrl_pad_in,
  input  logic       stat_clr,
  input  logic       abort_evt,
  input  logic       push,
  output staged_t    staged,
  output logic       abort_flag
);

  staged_t staged_nxt;
  logic    abort_nxt;
  logic    staged_en;
  logic    abort_en;

  always_comb begin
    staged_nxt = staged;
    staged_en  = 1'b0;
    if (abort_evt) begin
      staged_nxt = '0;
      staged_en  = 1'b1;
    end else if (ctrl_wr) begin
      staged_nxt.eop = ctrl_eop_in;
      staged_nxt.pad = ctrl_pad_in;
      staged_en      = 1'b1;
    end else if (push && staged.eop) begin
      staged_nxt = '0;
      staged_en  = 1'b1;
    end
  end

  always_comb begin
    abort_nxt = abort_flag;
    abort_en  = 1'b0;
    if (abort_evt) begin
      abort_nxt = 1'b1;
      abort_en  = 1'b1;
    end else if (stat_clr) begin
      abort_nxt = 1'b0;
      abort_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= '0;
    end else if (staged_en) begin
      staged <= staged_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_flag <= 1'b0;
    end else if (abort_en) begin
      abort_flag <= abort_nxt;
    end
  end

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> abort_flag) else $error("abort flag not set"); // R8

  AST_EOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (push && staged.eop && !ctrl_wr) |=> (staged == '0)) else $error("eop not cleared"); // R6

  AST_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (staged == '0)) else $error("staged fields survive abort"); // R8

endmodule

// File: rtl/eth_txw_frame.sv
module eth_txw_frame
  import eth_txw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    nb_wr,
  input  logic    wt_wr,
  input  logic    disc_req,
  input  logic    room_one,
  input  logic    abort_flag,
  input  staged_t staged,
  output logic    push,
  output logic    sop,
  output logic    eop,
  output logic [1:0] pad,
  output logic    wait_req,
  output logic    abort_evt,
  output logic    abort_pulse
);

  logic in_frame;
  logic in_frame_nxt;
  logic in_frame_en;
  logic nb_fail;
  logic data_wr;

  always_comb begin
    data_wr     = nb_wr || wt_wr;
    nb_fail     = nb_wr && !abort_flag && !room_one;
    push        = data_wr && !abort_flag && room_one;
    wait_req    = wt_wr && !abort_flag && !room_one;
    abort_evt   = nb_fail || disc_req;
    abort_pulse = abort_evt && in_frame;
    sop         = !in_frame;
    eop         = staged.eop;
    pad         = staged.eop ? staged.pad : 2'd0;
  end

  always_comb begin
    in_frame_nxt = in_frame;
    in_frame_en  = 1'b0;
    if (abort_evt) begin
      in_frame_nxt = 1'b0;
      in_frame_en  = 1'b1;
    end else if (push) begin
      in_frame_nxt = !staged.eop;
      in_frame_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
    end else if (in_frame_en) begin
      in_frame <= in_frame_nxt;
    end
  end

  AST_SOP_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !in_frame) else $error("frame survives abort"); // R9

  AST_DROP_WHILE_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> (!push && !wait_req)) else $error("data taken while aborted"); // R10

endmodule

// File: rtl/eth_tx_wrport.sv
module eth_tx_wrport
  import eth_txw_pkg::*;
#(
  parameter int FREE_W      = 6,
  parameter int CHUNK_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        csr_addr,
  input  logic              csr_write,
  input  logic              csr_read,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              csr_waitreq,
  input  logic [FREE_W-1:0] buf_free,
  output logic              buf_wr_en,
  output logic [31:0]       buf_wr_data,
  output logic              buf_wr_sop,
  output logic              buf_wr_eop,
  output logic [1:0]        buf_wr_pad,
  output logic              buf_abort
);

  logic [1:0] rst_q;
  logic       rst_sync_n;
  reg_sel_e   sel;
  logic       nb_wr, wt_wr, ctrl_wr, disc_req, stat_clr;
  logic       room_one, room_chunk;
  logic       abort_flag, abort_evt, push;
  staged_t    staged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_q[1];

  always_comb begin
    sel      = reg_sel_e'(csr_addr);
    nb_wr    = csr_write && (sel == SEL_DATA_NB);
    wt_wr    = csr_write && (sel == SEL_DATA_WT);
    disc_req = csr_write && (sel == SEL_CTRL) && csr_wdata[CTRL_DISC_BIT];
    ctrl_wr  = csr_write && (sel == SEL_CTRL) && !csr_wdata[CTRL_DISC_BIT];
    stat_clr = csr_write && (sel == SEL_STAT) && csr_wdata[STAT_ABT_BIT];
  end

  eth_txw_room #(.FREE_W(FREE_W), .CHUNK_WORDS(CHUNK_WORDS)) u_room (
    .buf_free   (buf_free),
    .room_one   (room_one),
    .room_chunk (room_chunk)
  );

  eth_txw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctrl_wr     (ctrl_wr),
    .ctrl_eop_in (csr_wdata[CTRL_EOP_BIT]),
    .ctrl_pad_in (csr_wdata[CTRL_PAD_LSB +: 2]),
    .stat_clr    (stat_clr),
    .abort_evt   (abort_evt),
    .push        (push),
    .staged      (staged),
    .abort_flag  (abort_flag)
  );

  eth_txw_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .nb_wr       (nb_wr),
    .wt_wr       (wt_wr),
    .disc_req    (disc_req),
    .room_one    (room_one),
    .abort_flag  (abort_flag),
    .staged      (staged),
    .push        (push),
    .sop         (buf_wr_sop),
    .eop         (buf_wr_eop),
    .pad         (buf_wr_pad),
    .wait_req    (csr_waitreq),
    .abort_evt   (abort_evt),
    .abort_pulse (buf_abort)
  );

  assign buf_wr_en   = push;
  assign buf_wr_data = csr_wdata;

  always_comb begin
    csr_rdata = '0;
    if (csr_read) begin
      unique case (sel)
        SEL_CTRL: begin
          csr_rdata[CTRL_EOP_BIT]       = staged.eop;
          csr_rdata[CTRL_PAD_LSB +: 2]  = staged.pad;
        end
        SEL_STAT: begin
          csr_rdata[STAT_ONE_BIT] = room_one;
          csr_rdata[STAT_CHK_BIT] = room_chunk;
          csr_rdata[STAT_ABT_BIT] = abort_flag;
        end
        default: csr_rdata = '0;
      endcase
    end
  end

  AST_NB_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nb_wr && buf_free == '0) |-> !buf_wr_en) else $error("push into full buffer"); // R4

  AST_WAIT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    csr_waitreq |-> (buf_free == '0 && !buf_wr_en)) else $error("bad wait request"); // R5

  AST_PAD_ONLY_AT_EOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_wr_en && !buf_wr_eop) |-> (buf_wr_pad == 2'd0)) else $error("pad on mid word"); // R7

  AST_ONE_MARKER_SRC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    buf_abort |-> !buf_wr_en) else $error("push with abort"); // R9

endmodule

// File: tb/test_eth_tx_wrport.sv
module test_eth_tx_wrport;

  localparam int FREE_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        csr_addr = 2'd0;
  logic              csr_write = 1'b0;
  logic              csr_read = 1'b0;
  logic [31:0]       csr_wdata = '0;
  logic [31:0]       csr_rdata;
  logic              csr_waitreq;
  logic [FREE_W-1:0] buf_free = 6'd10;
  logic              buf_wr_en;
  logic [31:0]       buf_wr_data;
  logic              buf_wr_sop, buf_wr_eop, buf_abort;
  logic [1:0]        buf_wr_pad;

  int n_cmp = 0;
  int n_bad = 0;
  logic c_en, c_sop, c_eop, c_abt, c_wait;
  logic [1:0]  c_pad;
  logic [31:0] c_data;

  always #2.5 clk = ~clk;

  eth_tx_wrport #(.FREE_W(FREE_W), .CHUNK_WORDS(8)) i_eth_tx_wrport (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_write(csr_write),
    .csr_read(csr_read), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_waitreq(csr_waitreq), .buf_free(buf_free), .buf_wr_en(buf_wr_en),
    .buf_wr_data(buf_wr_data), .buf_wr_sop(buf_wr_sop), .buf_wr_eop(buf_wr_eop),
    .buf_wr_pad(buf_wr_pad), .buf_abort(buf_abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic capture();
    c_en = buf_wr_en; c_sop = buf_wr_sop; c_eop = buf_wr_eop; c_pad = buf_wr_pad;
    c_abt = buf_abort; c_wait = csr_waitreq; c_data = buf_wr_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_write = 1'b1;
    #1 capture();
    @(negedge clk);
    csr_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_read = 1'b1;
    #1 d = csr_rdata;
    @(negedge clk);
    csr_read = 1'b0;
  endtask

  task automatic push_word(input logic [1:0] a, input logic [31:0] d,
                           input logic sop, input logic eop, input logic [1:0] pad, input string req);
    wr(a, d);
    chk({req, " en"}, 32'(c_en), 32'd1);
    chk({req, " data"}, c_data, d);
    chk({req, " sop"}, 32'(c_sop), 32'(sop));
    chk({req, " eop"}, 32'(c_eop), 32'(eop));
    chk({req, " pad"}, 32'(c_pad), 32'(pad));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk("R1 idle en", 32'(buf_wr_en), 32'd0);
    chk("R1 idle abort", 32'(buf_abort), 32'd0);
    rd(2'd3, v); chk("R1 status", v, 32'd3);
    rd(2'd2, v); chk("R1 control", v, 32'd0);
  endtask

  task automatic t_room();
    logic [31:0] v;
    buf_free = 6'd0; rd(2'd3, v); chk("R2 free0", v, 32'd0);
    buf_free = 6'd1; rd(2'd3, v); chk("R2 free1", v, 32'd1);
    buf_free = 6'd7; rd(2'd3, v); chk("R2 free7", v, 32'd1);
    buf_free = 6'd8; rd(2'd3, v); chk("R2 free8", v, 32'd3);
    buf_free = 6'd10;
  endtask

  task automatic t_frame();
    logic [31:0] v;
    push_word(2'd0, 32'hA0A0_0001, 1'b1, 1'b0, 2'd0, "R3 first");
    push_word(2'd1, 32'hA0A0_0002, 1'b0, 1'b0, 2'd0, "R7 mid");
    wr(2'd2, 32'h5);
    rd(2'd2, v); chk("R6 staged", v, 32'd5);
    push_word(2'd0, 32'hA0A0_0003, 1'b0, 1'b1, 2'd2, "R6 last");
    rd(2'd2, v); chk("R6 self clear", v, 32'd0);
    wr(2'd2, 32'h7);
    push_word(2'd0, 32'hB0B0_0001, 1'b1, 1'b1, 2'd3, "R6 single");
    push_word(2'd0, 32'hB0B0_0002, 1'b1, 1'b0, 2'd0, "R3 sop again");
  endtask

  task automatic t_nb_full();
    logic [31:0] v;
    buf_free = 6'd0;
    wr(2'd0, 32'hDEAD_0001);
    chk("R4 no push", 32'(c_en), 32'd0);
    chk("R9 abort pulse", 32'(c_abt), 32'd1);
    chk("R4 no wait", 32'(c_wait), 32'd0);
    rd(2'd3, v); chk("R4 flag", v, 32'd4);
    wr(2'd3, 32'h4);
    rd(2'd3, v); chk("R10 cleared", v, 32'd0);
    buf_free = 6'd10;
    push_word(2'd0, 32'hC0C0_0001, 1'b1, 1'b0, 2'd0, "R10 sop");
  endtask

  task automatic t_wait();
    @(negedge clk);
    buf_free = 6'd0;
    csr_addr = 2'd1; csr_wdata = 32'hC0C0_0002; csr_write = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R5 wait held", 32'(csr_waitreq), 32'd1);
      chk("R5 no push", 32'(buf_wr_en), 32'd0);
      @(negedge clk);
    end
    buf_free = 6'd2;
    #1;
    chk("R5 wait drop", 32'(csr_waitreq), 32'd0);
    chk("R5 push", 32'(buf_wr_en), 32'd1);
    chk("R5 mid sop", 32'(buf_wr_sop), 32'd0);
    @(negedge clk);
    csr_write = 1'b0;
    buf_free = 6'd10;
  endtask

  task automatic t_discard();
    logic [31:0] v;
    wr(2'd2, 32'hB);
    chk("R8 discard no push", 32'(c_en), 32'd0);
    chk("R9 discard pulse", 32'(c_abt), 32'd1);
    rd(2'd3, v); chk("R8 flag", v, 32'd7);
    rd(2'd2, v); chk("R8 staged clear", v, 32'd0);
    wr(2'd0, 32'hEEEE_0001);
    chk("R10 nb swallowed", 32'(c_en), 32'd0);
    chk("R10 no second pulse", 32'(c_abt), 32'd0);
    buf_free = 6'd0;
    wr(2'd1, 32'hEEEE_0002);
    chk("R10 wt swallowed", 32'(c_en), 32'd0);
    chk("R10 wt no wait", 32'(c_wait), 32'd0);
    buf_free = 6'd10;
    wr(2'd3, 32'h4);
    wr(2'd2, 32'h1);
    push_word(2'd0, 32'hF0F0_0001, 1'b1, 1'b1, 2'd0, "R10 restart");
  endtask

  task automatic t_idle_abort();
    logic [31:0] v;
    wr(2'd2, 32'h8);
    chk("R9 idle no pulse", 32'(c_abt), 32'd0);
    rd(2'd3, v); chk("R8 idle flag", v, 32'd7);
    wr(2'd3, 32'h4);
    rd(2'd3, v); chk("R10 idle clear", v, 32'd3);
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_room();
    t_frame();
    t_nb_full();
    t_wait();
    t_discard();
    t_idle_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule